// File: doc/BRIEF.md
# Output-Compare PWM Timer Channel

This block is a single timer channel that builds a pulse-width-modulated waveform from a free-running up-counter. A power-of-two prescaler divides the bus clock into count ticks. The counter climbs from zero to a modulo limit and then wraps, so the modulo value sets the period. On each wrap the pin goes to its active level. When the count reaches the channel compare value, the pin goes back to its inactive level. The distance from wrap to match is the pulse width.

The channel compare register has no shadow copy. A write lands at the next clock edge and is used by the very next count tick. Software that changes the width at a badly chosen moment can therefore skip a match for one period. This behaviour is intended, and the block reproduces it exactly. A polarity input picks whether the active level is high or low. Two flag outputs pulse once for each wrap and once for each match.

Top module: `pwm_oc_channel`

## Requirements
- R1: The counter starts at 0 and steps by one per tick up to the modulo value. The tick after that returns it to 0, so the period is modulo+1 ticks and `ovf_o` pulses once per period.
- R2: With select value n (0 to 6) there is one tick every 2^n bus clocks; the first tick falls on edge 2^n after reset. Any select value above 6 acts as 6.
- R3: With select 0 and modulo 255, successive `ovf_o` pulses are exactly 256 bus clocks apart.
- R4: In the cycle where `ovf_o` is high and `cmp_o` is low, `pwm_o` equals `pol_hi_i`. `pol_hi_i` = 1 means the active level is high.
- R5: When the count steps onto the channel compare value, `cmp_o` is high for that cycle and `pwm_o` shows the inactive level (the inverse of `pol_hi_i`).
- R6: With select 0, modulo 255 and compare 128, `pwm_o` sits at the active level for 128 of the 256 clocks in each period.
- R7: A value written with `chan_wr_i` is used from the next tick onward, in the current period. A value larger than the present count therefore matches in that same period.
- R8: Suppose a smaller compare value is written after the count has passed it, while the old value is still ahead. Then no match occurs for the rest of that period, and the pin stays active until the next wrap.
- R9: `ovf_o` and `cmp_o` each stay high for one bus clock per event, and they go high in the same cycle as the pin change they mark.
- R10: Reset behaviour. While `rst_ni` is low, `pwm_o` shows the inactive level and both flags are low. The compare register resets to all ones. The first wrap comes modulo+1 ticks after release and drives the pin active.
- R11: If the compare value is above the modulo value, no match ever occurs. `cmp_o` stays low, and the pin holds the active level for every whole period after the first wrap.
- R12: If the compare value is 0, the match falls on the wrap tick itself and takes priority. Both flags pulse together and the pin stays inactive (0 % duty).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| presc_sel_i | input | 3 | Prescaler exponent; the divide ratio is 2^n |
| modulo_i | input | 16 | Count limit; the period is this value plus 1 ticks |
| chan_val_i | input | 16 | New channel compare value |
| chan_wr_i | input | 1 | Loads `chan_val_i` into the compare register |
| pol_hi_i | input | 1 | 1: the pulse is high; 0: the pulse is low |
| pwm_o | output | 1 | PWM pin |
| ovf_o | output | 1 | One-cycle pulse on counter wrap |
| cmp_o | output | 1 | One-cycle pulse on compare match |

## Verification
Every result of this block, whether a pin change, `ovf_o` or `cmp_o`, appears right after the bus-clock edge that carries the count tick causing it. A compare-register write is seen by the tick at the following edge. The driver therefore works out, before each edge, what the three outputs must show after that edge. It queues this prediction, and the monitor compares it against the outputs one time unit after the edge. A second monitor counts, for each period, the clocks and the active clocks between `ovf_o` pulses. The missed-compare and immediate-write scenarios also count `cmp_o` pulses over the window from the write up to the next wrap.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W_DEF   = 16;
  localparam int unsigned SEL_W_DEF   = 3;
  localparam int unsigned MAX_EXP_DEF = 6;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned SEL_W   = pwm_pkg::SEL_W_DEF,
  parameter int unsigned MAX_EXP = pwm_pkg::MAX_EXP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int unsigned DIV_W = (MAX_EXP > 0) ? MAX_EXP : 1;
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(MAX_EXP);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;
  logic [SEL_W-1:0] sel_eff;

  assign sel_eff = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;

  for (genvar i = 0; i < DIV_W; i++) begin : g_mask
    assign mask[i] = (sel_eff > SEL_W'(i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) div_q <= '0;
    else         div_q <= div_q + 1'b1;
  end

  // tick when all selected low bits are ones
  assign tick_o = ((div_q & mask) == mask);
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] modulo_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] nxt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = tick_i && (cnt_q == modulo_i);
  assign nxt_o  = (cnt_q == modulo_i) ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwm_out_ctl.sv
module pwm_out_ctl #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wrap_i,
  input  logic [CNT_W-1:0] nxt_i,
  input  logic [CNT_W-1:0] chan_i,
  input  logic             pol_hi_i,
  output logic             pwm_o,
  output logic             ovf_o,
  output logic             cmp_o
);
  logic match;
  logic act_q, ovf_q, cmp_q;

  // match on the value the counter is stepping onto
  assign match = tick_i && (nxt_i == chan_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      ovf_q <= 1'b0;
      cmp_q <= 1'b0;
    end else begin
      ovf_q <= wrap_i;
      cmp_q <= match;
      if (match)       act_q <= 1'b0;  // compare wins over wrap
      else if (wrap_i) act_q <= 1'b1;
    end
  end

  assign pwm_o = pol_hi_i ? act_q : ~act_q;
  assign ovf_o = ovf_q;
  assign cmp_o = cmp_q;
endmodule

// File: rtl/pwm_oc_channel.sv
module pwm_oc_channel #(
  parameter int unsigned CNT_W   = pwm_pkg::CNT_W_DEF,
  parameter int unsigned SEL_W   = pwm_pkg::SEL_W_DEF,
  parameter int unsigned MAX_EXP = pwm_pkg::MAX_EXP_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] presc_sel_i,
  input  logic [CNT_W-1:0] modulo_i,
  input  logic [CNT_W-1:0] chan_val_i,
  input  logic             chan_wr_i,
  input  logic             pol_hi_i,
  output logic             pwm_o,
  output logic             ovf_o,
  output logic             cmp_o
);
  logic             tick;
  logic             wrap;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic [CNT_W-1:0] chan_q;

  // unbuffered channel register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        chan_q <= '1;
    else if (chan_wr_i) chan_q <= chan_val_i;
  end

  pwm_prescaler #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_i (presc_sel_i),
    .tick_o(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .modulo_i(modulo_i),
    .cnt_o   (cnt_q),
    .nxt_o   (nxt),
    .wrap_o  (wrap)
  );

  pwm_out_ctl #(.CNT_W(CNT_W)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .wrap_i  (wrap),
    .nxt_i   (nxt),
    .chan_i  (chan_q),
    .pol_hi_i(pol_hi_i),
    .pwm_o   (pwm_o),
    .ovf_o   (ovf_o),
    .cmp_o   (cmp_o)
  );
endmodule

// File: rtl/pwm_oc_channel_chk.sv
module pwm_oc_channel_chk #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pol_hi_i,
  input logic [CNT_W-1:0] modulo_i,
  input logic             pwm_o,
  input logic             ovf_o,
  input logic             cmp_o,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] chan_i
);
  a_r1_wrap_to_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cnt_i == '0);

  a_r4_active_on_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !cmp_o) |-> pwm_o == pol_hi_i);

  a_r5_inactive_on_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |-> pwm_o != pol_hi_i);

  a_r5_cmp_at_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_o |-> cnt_i == $past(chan_i));

  a_r9_ovf_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && modulo_i != '0) |=> !ovf_o);

  a_r9_cmp_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_o && modulo_i != '0) |=> !cmp_o);

  a_r10_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ovf_o && !cmp_o && $stable(pol_hi_i)) |-> $stable(pwm_o));
endmodule

bind pwm_oc_channel pwm_oc_channel_chk #(.CNT_W(CNT_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pol_hi_i(pol_hi_i),
  .modulo_i(modulo_i),
  .pwm_o   (pwm_o),
  .ovf_o   (ovf_o),
  .cmp_o   (cmp_o),
  .cnt_i   (cnt_q),
  .chan_i  (chan_q)
);

// File: tb/test_pwm_oc_channel.sv
`timescale 1ns/1ps
module test_pwm_oc_channel;
  typedef struct {
    logic  pwm;
    logic  ovf;
    logic  cmp;
    string tag;
  } item_t;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  presc_sel_i = '0;
  logic [15:0] modulo_i = '0;
  logic [15:0] chan_val_i = '0;
  logic        chan_wr_i = 1'b0;
  logic        pol_hi_i = 1'b1;
  logic        pwm_o, ovf_o, cmp_o;

  int n_chk = 0;
  int n_fail = 0;
  item_t q[$];

  // model state
  int    m_e, m_pos, m_chan, m_mod, m_exp;
  logic  m_act;
  string cur_tag;

  // period monitor
  int per_cnt, hi_cnt, last_per, last_hi, cmp_seen, ovf_seen;

  always #2.5 clk_i = ~clk_i;

  pwm_oc_channel i_pwm_oc_channel (
    .clk_i(clk_i), .rst_ni(rst_ni), .presc_sel_i(presc_sel_i),
    .modulo_i(modulo_i), .chan_val_i(chan_val_i), .chan_wr_i(chan_wr_i),
    .pol_hi_i(pol_hi_i), .pwm_o(pwm_o), .ovf_o(ovf_o), .cmp_o(cmp_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
  endtask

  // monitor: compare after each edge
  initial begin
    forever begin
      @(posedge clk_i);
      #1;
      if (rst_ni) begin
        if (ovf_o) begin
          last_per = per_cnt;
          last_hi  = hi_cnt;
          per_cnt  = 1;
          hi_cnt   = (pwm_o == pol_hi_i) ? 1 : 0;
          ovf_seen++;
        end else begin
          per_cnt++;
          if (pwm_o == pol_hi_i) hi_cnt++;
        end
        if (cmp_o) cmp_seen++;
      end
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_chk++;
        if (pwm_o !== it.pwm || ovf_o !== it.ovf || cmp_o !== it.cmp) begin
          n_fail++;
          $display("FAIL %s actual pwm/ovf/cmp %b%b%b expected %b%b%b",
                   it.tag, pwm_o, ovf_o, cmp_o, it.pwm, it.ovf, it.cmp);
        end
      end
    end
  end

  // reset, configure, release at a negedge
  task automatic do_reset(input logic [2:0] sel, input int modv, input logic pol);
    @(negedge clk_i);
    rst_ni = 1'b0;
    presc_sel_i = sel;
    modulo_i = 16'(modv);
    pol_hi_i = pol;
    chan_wr_i = 1'b0;
    @(negedge clk_i);
    chk(pwm_o == ~pol && !ovf_o && !cmp_o, "R10 reset state",
        {pwm_o, ovf_o, cmp_o}, {~pol, 2'b00});
    m_e = 0; m_pos = 0; m_chan = 16'hFFFF; m_mod = modv; m_act = 1'b0;
    m_exp = (sel > 3'd6) ? 6 : int'(sel);
    per_cnt = 0; hi_cnt = 0; last_per = -1; last_hi = -1;
    cmp_seen = 0; ovf_seen = 0;
    rst_ni = 1'b1;
  endtask

  // drive one edge; starts and ends at a negedge
  task automatic step(input logic wr, input int val);
    item_t it;
    chan_wr_i  = wr;
    chan_val_i = 16'(val);
    m_e++;
    it.ovf = 1'b0;
    it.cmp = 1'b0;
    if ((m_e % (1 << m_exp)) == 0) begin
      if (m_pos == m_mod) begin
        m_pos = 0;
        it.ovf = 1'b1;
        if (m_chan == 0) begin it.cmp = 1'b1; m_act = 1'b0; end
        else m_act = 1'b1;
      end else begin
        m_pos++;
        if (m_pos == m_chan) begin it.cmp = 1'b1; m_act = 1'b0; end
      end
    end
    if (wr) m_chan = val;
    it.pwm = pol_hi_i ? m_act : ~m_act;
    it.tag = cur_tag;
    q.push_back(it);
    @(negedge clk_i);
    chan_wr_i = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired, actual running expected done");
    summary();
    $finish;
  end

  initial begin
    int c0;
    // R3 R6: 8-bit resolution, 50 % duty
    do_reset(3'd0, 255, 1'b1);
    cur_tag = "R1 R3 R4 R5 R6 R9 R10";
    step(1'b1, 128);
    run(800);
    chk(last_per == 256, "R3 period clocks", last_per, 256);
    chk(last_hi == 128, "R6 active clocks", last_hi, 128);

    // R2: divide by 4, low polarity
    do_reset(3'd2, 9, 1'b0);
    cur_tag = "R2 R4 R5 R9";
    step(1'b1, 4);
    run(300);
    chk(last_per == 40, "R2 period div4", last_per, 40);
    chk(last_hi == 16, "R2 active div4", last_hi, 16);

    // R2: select 7 clamps to 64
    do_reset(3'd7, 3, 1'b1);
    cur_tag = "R2 clamp";
    step(1'b1, 1);
    run(1100);
    chk(last_per == 256, "R2 clamp period", last_per, 256);
    chk(last_hi == 64, "R2 clamp active", last_hi, 64);

    // R11: compare above modulo
    do_reset(3'd0, 20, 1'b1);
    cur_tag = "R11";
    step(1'b1, 30);
    run(100);
    chk(cmp_seen == 0, "R11 no compare", cmp_seen, 0);
    chk(last_hi == 21, "R11 full active", last_hi, 21);

    // R12: compare zero
    do_reset(3'd0, 15, 1'b1);
    cur_tag = "R12";
    step(1'b1, 0);
    run(80);
    chk(cmp_seen == ovf_seen && ovf_seen == 5, "R12 compare at wrap", cmp_seen, ovf_seen);
    chk(last_hi == 0, "R12 zero duty", last_hi, 0);

    // R7 R8: unbuffered writes
    do_reset(3'd0, 99, 1'b1);
    cur_tag = "R7 R8";
    step(1'b1, 60);
    while (!(m_e > 100 && m_pos == 50)) step(1'b0, 0);
    c0 = cmp_seen;
    step(1'b1, 40);
    while (m_pos != 0) step(1'b0, 0);
    chk(cmp_seen == c0, "R8 missed compare", cmp_seen - c0, 0);
    chk(last_hi == 100, "R8 active whole period", last_hi, 100);
    while (m_pos != 20) step(1'b0, 0);
    c0 = cmp_seen;
    step(1'b1, 70);
    while (m_pos != 0) step(1'b0, 0);
    chk(cmp_seen - c0 == 1, "R7 immediate write", cmp_seen - c0, 1);
    chk(last_hi == 70, "R7 new width same period", last_hi, 70);
    run(110);

    @(negedge clk_i);
    chk(q.size() == 0, "R1 queue drained", q.size(), 0);
    summary();
    $finish;
  end
endmodule